// File: doc/BRIEF.md
# Prioritized Interrupt Vector Controller

This block gathers every exception source of a small 16-bit processor core and turns them into the vector address that the core fetches when it takes an exception. It sorts the sources into a fixed ranking. The illegal-opcode trap comes first, then the software-interrupt/debug strobe, then the single X-masked request, then a bank of I-masked request lines. Each class owns a fixed even offset in one 256-byte vector page. The upper byte of that page comes from an 8-bit base register written over a simple write port. While the debug freeze mode is active, the upper byte is forced to 0xFF.

The core raises a one-cycle vector request strobe. On that edge the block captures the winning vector and holds it for the fetch, even if the requests change afterwards. If no unmasked request is left when the strobe arrives, the spurious slot at offset 0x80 is captured instead. I-masked requests are gated only by the current I mask bit, so an active request can be taken again, and nested, as soon as the core clears that bit inside a handler.

A wake-up output is derived without any register, so it still works while the block's clock is stopped in stop mode. There is no data stream at the block's edge. The vector request is a plain strobe with no back-pressure, and the vector output is a plain registered value.

Top module: `ivec_ctrl`

## Requirements
- R1: The base register resets to 0xFF. A cycle with `rb_wr` high loads `rb_wdata` into it at the clock edge, and the lower byte of the vector base is always 0x00.
- R2: While `freeze_mode` is high at the capture edge, the captured vector's upper byte is 0xFF whatever the base register holds.
- R3: `vec_addr` resets to 0xFF80. It is loaded only on a clock edge where `vec_req` is high, and it otherwise holds its value whatever the requests do.
- R4: `trap_req` captures offset 0xF8 and beats every other source.
- R5: `swi_req`, with no trap pending, captures offset 0xF6. It is not maskable.
- R6: `xreq` with `cpu_xmask` low, and neither trap nor swi pending, captures offset 0xF4. It beats every I-masked request.
- R7: I-masked line k (0 ≤ k < N_IREQ ≤ 57), with `cpu_imask` low, maps to offset 0x82 + 2k. The highest-numbered active line wins.
- R8: If no unmasked request is active at the capture edge, offset 0x80 (spurious) is captured.
- R9: `irq_pend` is high in the same cycle exactly when trap, swi, unmasked X or any unmasked I request is active.
- R10: `wake` equals `stop_mode` AND the pending condition of R9. It is formed without a clock, so it responds while the clock is stopped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock (may be stopped in stop mode) |
| rst_n | input | 1 | Active-low synchronous reset |
| rb_wr | input | 1 | Base register write strobe |
| rb_wdata | input | 8 | Base register write data (vector page upper byte) |
| ireq | input | N_IREQ | I-masked request lines, line k at offset 0x82+2k |
| xreq | input | 1 | X-masked request |
| swi_req | input | 1 | Software interrupt / debug request |
| trap_req | input | 1 | Illegal-opcode trap request |
| cpu_imask | input | 1 | Core I mask bit, high blocks `ireq` |
| cpu_xmask | input | 1 | Core X mask bit, high blocks `xreq` |
| stop_mode | input | 1 | Core is in stop mode |
| freeze_mode | input | 1 | Debug freeze active, base forced to 0xFF |
| vec_req | input | 1 | Vector fetch strobe from the core |
| irq_pend | output | 1 | An unmasked request is active |
| vec_addr | output | 16 | Captured vector address |
| wake | output | 1 | Wake-up indication while stopped |

## Verification
The properties assume that `rst_n` is asserted at the start and that all inputs change only between clock edges. Otherwise a capture could see a request half-updated. The bench drives every input one time unit after the rising edge and compares at the falling edge. The clock-stopped wake-up check leaves the clock low after a falling edge before it moves any request or mask, so no edge is produced during that window. Random phases keep register writes and freeze toggles sparse, so the base changes while captures of every class are still going on.

// File: rtl/ivec_pkg.sv
package ivec_pkg;
  localparam int unsigned IVEC_MAX_I  = 57;
  localparam logic [7:0]  OFS_SPUR    = 8'h80;
  localparam logic [7:0]  OFS_I0      = 8'h82;
  localparam logic [7:0]  OFS_X       = 8'hF4;
  localparam logic [7:0]  OFS_SWI     = 8'hF6;
  localparam logic [7:0]  OFS_TRAP    = 8'hF8;
  localparam logic [7:0]  PAGE_RESET  = 8'hFF;
  localparam logic [7:0]  PAGE_FREEZE = 8'hFF;

  typedef enum logic [2:0] {
    CLS_NONE,
    CLS_IREQ,
    CLS_XREQ,
    CLS_SWI,
    CLS_TRAP
  } ivec_cls_e;
endpackage

// File: rtl/ivec_page_reg.sv
module ivec_page_reg
  import ivec_pkg::*;
#(
  parameter int unsigned PAGE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr,
  input  logic [PAGE_W-1:0] wdata,
  input  logic              freeze,
  output logic [PAGE_W-1:0] page_eff
);
  logic [PAGE_W-1:0] page_q;

  always_ff @(posedge clk) begin
    if (!rst_n)  page_q <= PAGE_W'(PAGE_RESET);
    else if (wr) page_q <= wdata;
  end

  assign page_eff = freeze ? PAGE_W'(PAGE_FREEZE) : page_q;
endmodule

// File: rtl/ivec_ipri.sv
module ivec_ipri #(
  parameter int unsigned N_IREQ = 57,
  localparam int unsigned IW    = (N_IREQ > 1) ? $clog2(N_IREQ) : 1
) (
  input  logic [N_IREQ-1:0] req,
  output logic              hit,
  output logic [IW-1:0]     idx
);
  logic [N_IREQ-1:0] above;
  logic [N_IREQ-1:0] sel;

  genvar g;
  generate
    for (g = 0; g < N_IREQ; g++) begin : g_bit
      if (g == N_IREQ - 1) begin : g_top
        assign above[g] = 1'b0;
      end else begin : g_low
        assign above[g] = req[g+1] | above[g+1];
      end
      assign sel[g] = req[g] & ~above[g];
    end
  endgenerate

  always_comb begin
    idx = '0;
    for (int k = 0; k < N_IREQ; k++) begin
      if (sel[k]) idx = idx | IW'(k);
    end
  end

  assign hit = |req;
endmodule

// File: rtl/ivec_resolve.sv
module ivec_resolve
  import ivec_pkg::*;
#(
  parameter int unsigned N_IREQ = 57,
  localparam int unsigned IW    = (N_IREQ > 1) ? $clog2(N_IREQ) : 1,
  localparam int unsigned PADW  = 7 - IW
) (
  input  logic          i_hit,
  input  logic [IW-1:0] i_idx,
  input  logic          xreq,
  input  logic          xmask,
  input  logic          swi,
  input  logic          trap,
  input  logic          imask,
  output ivec_cls_e     cls,
  output logic [7:0]    ofs,
  output logic          pend
);
  logic [7:0] i_ofs;

  assign i_ofs = OFS_I0 + {{PADW{1'b0}}, i_idx, 1'b0};

  always_comb begin
    if (trap)                cls = CLS_TRAP;
    else if (swi)            cls = CLS_SWI;
    else if (xreq && !xmask) cls = CLS_XREQ;
    else if (i_hit && !imask) cls = CLS_IREQ;
    else                     cls = CLS_NONE;
  end

  always_comb begin
    unique case (cls)
      CLS_TRAP: ofs = OFS_TRAP;
      CLS_SWI:  ofs = OFS_SWI;
      CLS_XREQ: ofs = OFS_X;
      CLS_IREQ: ofs = i_ofs;
      default:  ofs = OFS_SPUR;
    endcase
  end

  assign pend = (cls != CLS_NONE);
endmodule

// File: rtl/ivec_ctrl.sv
module ivec_ctrl
  import ivec_pkg::*;
#(
  parameter int unsigned N_IREQ = 57,
  localparam int unsigned IW    = (N_IREQ > 1) ? $clog2(N_IREQ) : 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rb_wr,
  input  logic [7:0]        rb_wdata,
  input  logic [N_IREQ-1:0] ireq,
  input  logic              xreq,
  input  logic              swi_req,
  input  logic              trap_req,
  input  logic              cpu_imask,
  input  logic              cpu_xmask,
  input  logic              stop_mode,
  input  logic              freeze_mode,
  input  logic              vec_req,
  output logic              irq_pend,
  output logic [15:0]       vec_addr,
  output logic              wake
);
  logic [7:0]    page_eff;
  logic          i_hit;
  logic [IW-1:0] i_idx;
  ivec_cls_e     cls;
  logic [7:0]    ofs;
  logic          pend;

  ivec_page_reg #(.PAGE_W(8)) u_page (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr       (rb_wr),
    .wdata    (rb_wdata),
    .freeze   (freeze_mode),
    .page_eff (page_eff)
  );

  ivec_ipri #(.N_IREQ(N_IREQ)) u_ipri (
    .req (ireq),
    .hit (i_hit),
    .idx (i_idx)
  );

  ivec_resolve #(.N_IREQ(N_IREQ)) u_res (
    .i_hit (i_hit),
    .i_idx (i_idx),
    .xreq  (xreq),
    .xmask (cpu_xmask),
    .swi   (swi_req),
    .trap  (trap_req),
    .imask (cpu_imask),
    .cls   (cls),
    .ofs   (ofs),
    .pend  (pend)
  );

  // capture on the fetch strobe; held until the next strobe
  always_ff @(posedge clk) begin
    if (!rst_n)       vec_addr <= {PAGE_RESET, OFS_SPUR};
    else if (vec_req) vec_addr <= {page_eff, ofs};
  end

  assign irq_pend = pend;
  // no register on this path: valid with the clock stopped
  assign wake     = stop_mode & pend;
endmodule

// File: rtl/ivec_chk.sv
module ivec_chk #(
  parameter int unsigned N_IREQ = 57
) (
  input logic              clk,
  input logic              rst_n,
  input logic [N_IREQ-1:0] ireq,
  input logic              trap_req,
  input logic              swi_req,
  input logic              stop_mode,
  input logic              freeze_mode,
  input logic              vec_req,
  input logic              irq_pend,
  input logic [15:0]       vec_addr,
  input logic              wake
);
  a_r10_no_wake_awake: assert property (@(posedge clk) disable iff (!rst_n)
    !stop_mode |-> !wake);
  a_r10_wake_on_trap: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_mode && trap_req) |-> wake);
  a_r9_pend_swi: assert property (@(posedge clk) disable iff (!rst_n)
    swi_req |-> irq_pend);
  a_r4_trap_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && trap_req) |=> (vec_addr[7:0] == 8'hF8));
  a_r8_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && !irq_pend) |=> (vec_addr[7:0] == 8'h80));
  a_r2_freeze_page: assert property (@(posedge clk) disable iff (!rst_n)
    (vec_req && freeze_mode) |=> (vec_addr[15:8] == 8'hFF));
  a_r3_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_req |=> $stable(vec_addr));
  a_r7_even_slot: assert property (@(posedge clk) disable iff (!rst_n)
    vec_addr[0] == 1'b0);
endmodule

bind ivec_ctrl ivec_chk #(.N_IREQ(N_IREQ)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .ireq        (ireq),
  .trap_req    (trap_req),
  .swi_req     (swi_req),
  .stop_mode   (stop_mode),
  .freeze_mode (freeze_mode),
  .vec_req     (vec_req),
  .irq_pend    (irq_pend),
  .vec_addr    (vec_addr),
  .wake        (wake)
);

// File: tb/ivec_ctrl_bench.sv
module ivec_ctrl_bench;
  localparam int N = 57;

  logic          clk = 1'b0;
  logic          clk_en = 1'b1;
  logic          rst_n = 1'b0;
  logic          rb_wr = 1'b0;
  logic [7:0]    rb_wdata = '0;
  logic [N-1:0]  ireq = '0;
  logic          xreq = 1'b0, swi_req = 1'b0, trap_req = 1'b0;
  logic          cpu_imask = 1'b0, cpu_xmask = 1'b0;
  logic          stop_mode = 1'b0, freeze_mode = 1'b0, vec_req = 1'b0;
  logic          irq_pend, wake;
  logic [15:0]   vec_addr;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 0;

  // reference state
  logic [7:0]  m_page;
  logic [15:0] m_vec;
  string       m_tag;

  ivec_ctrl #(.N_IREQ(N)) u_ivec_ctrl (
    .clk(clk), .rst_n(rst_n), .rb_wr(rb_wr), .rb_wdata(rb_wdata),
    .ireq(ireq), .xreq(xreq), .swi_req(swi_req), .trap_req(trap_req),
    .cpu_imask(cpu_imask), .cpu_xmask(cpu_xmask), .stop_mode(stop_mode),
    .freeze_mode(freeze_mode), .vec_req(vec_req), .irq_pend(irq_pend),
    .vec_addr(vec_addr), .wake(wake)
  );

  always begin
    #4;
    if (clk_en) clk = ~clk;
  end

  function automatic bit ref_pend();
    return trap_req || swi_req || (xreq && !cpu_xmask) ||
           (!cpu_imask && (ireq != '0));
  endfunction

  function automatic logic [7:0] ref_ofs(output string tag);
    int top = -1;
    for (int k = 0; k < N; k++) if (ireq[k]) top = k;
    if (trap_req)                      begin tag = "R4"; return 8'hF8; end
    if (swi_req)                       begin tag = "R5"; return 8'hF6; end
    if (xreq && !cpu_xmask)            begin tag = "R6"; return 8'hF4; end
    if (!cpu_imask && top >= 0)        begin tag = "R7"; return 8'(8'h82 + 2*top); end
    tag = "R8";
    return 8'h80;
  endfunction

  task automatic chk(input string tag, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model, advanced on each rising edge
  always @(posedge clk) begin
    string t;
    logic [7:0] o;
    cyc++;
    if (!rst_n) begin
      m_page = 8'hFF;
      m_vec  = 16'hFF80;
      m_tag  = "R3";
    end else begin
      if (vec_req) begin
        o = ref_ofs(t);
        m_vec = {(freeze_mode ? 8'hFF : m_page), o};
        m_tag = freeze_mode ? {t, "/R2"} : t;
      end else m_tag = "R3";
      if (rb_wr) m_page = rb_wdata;
    end
  end

  // compare every cycle, away from the active edge
  always @(negedge clk) begin
    if (!done && cyc > 0) begin
      chk({"vec ", m_tag}, vec_addr, m_vec);
      chk("R9 pend", 16'(irq_pend), 16'(ref_pend()));
      chk("R10 wake", 16'(wake), 16'(stop_mode && ref_pend()));
    end
  end

  always @(posedge clk) begin
    if (cyc > 60000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic capture(input string tag, input logic [15:0] exp);
    vec_req = 1'b1;
    step();
    vec_req = 1'b0;
    @(negedge clk);
    chk(tag, vec_addr, exp);
    step();
  endtask

  task automatic clear_reqs();
    ireq = '0; xreq = 0; swi_req = 0; trap_req = 0;
    cpu_imask = 0; cpu_xmask = 0;
  endtask

  initial begin
    repeat (3) step();
    @(negedge clk);
    chk("R3 reset vector", vec_addr, 16'hFF80);
    step();
    rst_n = 1'b1;
    step();

    capture("R8 idle spurious", 16'hFF80);
    capture("R1 reset page", 16'hFF80);

    rb_wr = 1; rb_wdata = 8'h12; step(); rb_wr = 0;
    ireq[0] = 1;
    capture("R1 R7 line0", 16'h1282);
    ireq[3] = 1; ireq[10] = 1;
    capture("R7 highest line", 16'h1296);
    ireq = '0; ireq[N-1] = 1;
    capture("R7 top line", 16'h12F2);
    cpu_imask = 1;
    capture("R8 masked spurious", 16'h1280);
    xreq = 1; cpu_imask = 0;
    capture("R6 x over i", 16'h12F4);
    cpu_xmask = 1;
    capture("R7 x masked", 16'h12F2);
    swi_req = 1; cpu_xmask = 0;
    capture("R5 swi", 16'h12F6);
    trap_req = 1;
    capture("R4 trap", 16'h12F8);
    freeze_mode = 1;
    capture("R2 freeze page", 16'hFFF8);
    freeze_mode = 0;
    clear_reqs();
    capture("R8 cleared", 16'h1280);
    // hold: requests change but no strobe
    ireq[5] = 1; trap_req = 1;
    step(); step();
    @(negedge clk);
    chk("R3 hold", vec_addr, 16'h1280);
    chk("R9 pend trap", 16'(irq_pend), 16'h1);
    clear_reqs();
    step();

    // stop with the clock halted
    stop_mode = 1; cpu_imask = 0;
    @(negedge clk);
    clk_en = 0;
    #2;
    chk("R10 idle no wake", 16'(wake), 16'h0);
    ireq[20] = 1; #3;
    chk("R10 wake clock off", 16'(wake), 16'h1);
    cpu_imask = 1; #3;
    chk("R10 masked no wake", 16'(wake), 16'h0);
    cpu_imask = 0; ireq = '0; stop_mode = 0; #3;
    clk_en = 1;
    step();

    // random phase
    for (int n = 0; n < 3000; n++) begin
      for (int k = 0; k < N; k++) ireq[k] = ($urandom % 24 == 0);
      xreq        = ($urandom % 6 == 0);
      swi_req     = ($urandom % 20 == 0);
      trap_req    = ($urandom % 25 == 0);
      cpu_imask   = ($urandom % 4 == 0);
      cpu_xmask   = ($urandom % 3 == 0);
      stop_mode   = ($urandom % 5 == 0);
      if ($urandom % 30 == 0) freeze_mode = ~freeze_mode;
      rb_wr       = ($urandom % 40 == 0);
      rb_wdata    = 8'($urandom);
      vec_req     = ($urandom % 3 == 0);
      step();
    end
    vec_req = 0; rb_wr = 0;
    step();
    @(negedge clk);
    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule